// File: doc/BRIEF.md
# Two-Wire Master Status and Interrupt Unit

This block keeps the status flags, the interrupt mask and the interrupt line of a two-wire (I2C-style) master controller. A byte-shifting engine reports what it is doing through single-cycle event strobes. Those strobes are: the holding register was loaded, the holding register was handed to the shifter, the shifter ran empty, a STOP went out, a NACK came back, a received byte is ready, and an underrun occurred. A small register bus lets software write the control, interrupt-enable and interrupt-disable registers, write a transmit byte and read status and mask.

The transmit-complete flag is not a latched event. It is computed from live state: it is high only while nothing sits in the holding register, the shifter is idle and a STOP has gone out. It is therefore already high after reset. It drops as soon as a byte is loaded or a START is requested. A NACK raises transmit-complete, the NACK flag and transmit-ready in the same cycle. Because transmit-ready doubles as the DMA request, a DMA write can follow at once and pull transmit-complete low again. For that reason the NACK flag is sticky and has its own mask bit, so that software can still see that the transfer failed.

Top module: `twi_stat_irq`

## Requirements
- R1: After a synchronous active-low reset, the status register reads 0x0005 (transmit-complete and transmit-ready set), the mask reads 0x0000, the interrupt output is 0 and the DMA request is 1.
- R2: Transmit-complete (status bit 0) is 1 exactly when the holding register is empty, the shifter is idle and a STOP has been sent since the last load or START. Reading the status does not clear it.
- R3: A holding-register load clears transmit-complete and transmit-ready (status bit 2) from the next cycle. A load is either a bus write to offset 0x34 or the load event input. Transmit-ready returns when the hold-to-shift event fires. The DMA request output always equals transmit-ready.
- R4: A bus write to the control register at offset 0x00 with bit 0 (START) set clears transmit-complete from the next cycle. A write with bit 0 clear leaves it unchanged.
- R5: A NACK event sets transmit-complete, transmit-ready and NACK (status bit 8) together in the next cycle, overriding any load or START in the same cycle.
- R6: NACK and underrun (status bit 7) are sticky. A read of the status register at offset 0x20 clears both. An event arriving in the same cycle as that read keeps its flag set.
- R7: Receive-ready (status bit 1) is set by the byte-ready event and cleared by a bus read of offset 0x30.
- R8: Writing 1s to offset 0x24 sets the matching mask bits, and writing 1s to offset 0x28 clears them. Only bits 0, 1, 2, 7 and 8 can be set. The mask reads back at offset 0x2C.
- R9: The interrupt output is a register holding the OR of (status AND mask). It follows a change of status or mask one cycle later.
- R10: Bus writes to the status (0x20) and mask (0x2C) offsets change nothing.
- R11: Read data is registered. It appears one cycle after the read strobe, carries the register value of the read cycle, and is 0 for any offset other than 0x20 and 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ev_hold_load | input | 1 | Holding register loaded by the DMA path |
| ev_hold_to_shift | input | 1 | Holding register moved into the shifter |
| ev_shift_empty | input | 1 | Shifter finished its byte |
| ev_stop_sent | input | 1 | STOP condition placed on the bus |
| ev_nack | input | 1 | Slave did not acknowledge |
| ev_rx_ready | input | 1 | Received byte available |
| ev_underrun | input | 1 | Transmit underrun |
| irq | output | 1 | Level interrupt |
| dma_tx_req | output | 1 | Transmit request for a DMA engine |

## Verification
A full transmit is walked step by step: load, hold-to-shift, shifter empty, then STOP. After each step the status is read, so a transmit-complete that ignores any one of its three conditions shows up at the step where that condition is the last one missing. A NACK is injected while a DMA load is pending, and again with the NACK mask bit enabled. This separates a NACK that sets all three flags from one that only sets its own flag, and it confirms that the error survives the next load. Status reads are placed in the same cycle as an underrun event, and writes are aimed at read-only offsets. The bench compares the interrupt and DMA request against its own behavioural model on every cycle.

// File: rtl/twi_stat_pkg.sv
// Package: bit positions and register offsets shared by the status unit.
// Assumes the bus data width is at least 9 bits.
package twi_stat_pkg;
    localparam int unsigned BIT_TXCOMP = 0;
    localparam int unsigned BIT_RXRDY  = 1;
    localparam int unsigned BIT_TXRDY  = 2;
    localparam int unsigned BIT_UNRE   = 7;
    localparam int unsigned BIT_NACK   = 8;
    localparam int unsigned CTRL_START = 0;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h20;
    localparam logic [7:0] OFS_IEN    = 8'h24;
    localparam logic [7:0] OFS_IDIS   = 8'h28;
    localparam logic [7:0] OFS_IMASK  = 8'h2C;
    localparam logic [7:0] OFS_RXHOLD = 8'h30;
    localparam logic [7:0] OFS_TXHOLD = 8'h34;

    // Indices into the sticky flag vector
    localparam int unsigned STK_NACK = 0;
    localparam int unsigned STK_UNRE = 1;
    localparam int unsigned STK_RX   = 2;
    localparam int unsigned STK_N    = 3;
endpackage

// File: rtl/twi_tx_track.sv
// Tracks holding register, shifter and STOP state and derives the live
// transmit-complete and transmit-ready levels from them.
// Assumes event strobes are single-cycle; NACK overrides all else.
module twi_tx_track (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic to_shift,
    input  logic shift_empty,
    input  logic stop_sent,
    input  logic start,
    input  logic nack,
    output logic txcomp,
    output logic txrdy
);
    logic hold_full;
    logic shift_busy;
    logic stop_done;

    // Holding register occupancy: a load fills it, the shifter drains it
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_full <= 1'b0;
        else if (nack)     hold_full <= 1'b0;
        else if (load)     hold_full <= 1'b1;
        else if (to_shift) hold_full <= 1'b0;
    end

    // Shifter activity: busy from hand-over until it reports empty
    always_ff @(posedge clk) begin
        if (!rst_n)           shift_busy <= 1'b0;
        else if (nack)        shift_busy <= 1'b0;
        else if (to_shift)    shift_busy <= 1'b1;
        else if (shift_empty) shift_busy <= 1'b0;
    end

    // STOP seen since the last load or START; high out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)             stop_done <= 1'b1;
        else if (nack)          stop_done <= 1'b1;
        else if (load || start) stop_done <= 1'b0;
        else if (stop_sent)     stop_done <= 1'b1;
    end

    // Live levels computed from the tracked state
    always_comb begin
        txcomp = !hold_full && !shift_busy && stop_done;
        txrdy  = !hold_full;
    end

    a_r3_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !nack) |=> (!txcomp && !txrdy));
    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !nack) |=> !txcomp);
    a_r5_nack_restores: assert property (@(posedge clk) disable iff (!rst_n)
        nack |=> (txcomp && txrdy));
endmodule

// File: rtl/twi_sticky_flags.sv
// A vector of sticky flags: each bit is set by its event and cleared by
// its clear strobe, with the event winning when both arrive together.
module twi_sticky_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: set dominates clear
        always_ff @(posedge clk) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (set_ev[i]) flags[i] <= 1'b1;
            else if (clr_ev[i]) flags[i] <= 1'b0;
        end

        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flags[i]);
        a_r6_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr_ev[i]) |=> flags[i]);
    end
endmodule

// File: rtl/twi_irq_mask.sv
// Interrupt mask with set and clear write ports, plus the registered
// interrupt line. Only the bits in SRC can ever be set.
module twi_irq_mask #(
    parameter int unsigned DW = 16,
    parameter logic [DW-1:0] SRC = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_wr,
    input  logic          clr_wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status,
    output logic [DW-1:0] mask,
    output logic          irq
);
    // Mask update: clear applied after set
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else begin
            if (set_wr && clr_wr) mask <= (mask | (wdata & SRC)) & ~wdata;
            else if (set_wr)      mask <= mask | (wdata & SRC);
            else if (clr_wr)      mask <= mask & ~wdata;
        end
    end

    // Registered interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status & mask);
    end

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((mask & $past(wdata)) == '0));
    a_r8_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && !clr_wr) |=> ((mask & $past(wdata) & SRC) == ($past(wdata) & SRC)));
endmodule

// File: rtl/twi_stat_irq.sv
// Top of the status and interrupt unit: decodes the register bus, builds
// the status word from the transmit tracker and sticky flags, and returns
// registered read data. Assumes one bus access per cycle.
module twi_stat_irq
    import twi_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_hold_load,
    input  logic              ev_hold_to_shift,
    input  logic              ev_shift_empty,
    input  logic              ev_stop_sent,
    input  logic              ev_nack,
    input  logic              ev_rx_ready,
    input  logic              ev_underrun,
    output logic              irq,
    output logic              dma_tx_req
);
    localparam logic [DATA_W-1:0] SRC_BITS =
        (DATA_W'(1) << BIT_TXCOMP) | (DATA_W'(1) << BIT_RXRDY) |
        (DATA_W'(1) << BIT_TXRDY)  | (DATA_W'(1) << BIT_UNRE)  |
        (DATA_W'(1) << BIT_NACK);

    logic wr_ctrl, wr_ien, wr_idis, wr_txhold, rd_status, rd_rxhold;
    logic load, start, txcomp, txrdy;
    logic [STK_N-1:0] stk_set, stk_clr, stk_q;
    logic [DATA_W-1:0] status, mask;

    // Register bus decode
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_ien    = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
        wr_idis   = bus_wr && (bus_addr == ADDR_W'(OFS_IDIS));
        wr_txhold = bus_wr && (bus_addr == ADDR_W'(OFS_TXHOLD));
        rd_status = bus_rd && (bus_addr == ADDR_W'(OFS_STATUS));
        rd_rxhold = bus_rd && (bus_addr == ADDR_W'(OFS_RXHOLD));
        load      = wr_txhold || ev_hold_load;
        start     = wr_ctrl && bus_wdata[CTRL_START];
    end

    twi_tx_track u_tx (
        .clk(clk), .rst_n(rst_n), .load(load), .to_shift(ev_hold_to_shift),
        .shift_empty(ev_shift_empty), .stop_sent(ev_stop_sent),
        .start(start), .nack(ev_nack), .txcomp(txcomp), .txrdy(txrdy)
    );

    // Sticky flag set and clear sources
    always_comb begin
        stk_set = '0;
        stk_clr = '0;
        stk_set[STK_NACK] = ev_nack;
        stk_set[STK_UNRE] = ev_underrun;
        stk_set[STK_RX]   = ev_rx_ready;
        stk_clr[STK_NACK] = rd_status;
        stk_clr[STK_UNRE] = rd_status;
        stk_clr[STK_RX]   = rd_rxhold;
    end

    twi_sticky_flags #(.N(STK_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_ev(stk_set), .clr_ev(stk_clr), .flags(stk_q)
    );

    // Status word assembly
    always_comb begin
        status             = '0;
        status[BIT_TXCOMP] = txcomp;
        status[BIT_RXRDY]  = stk_q[STK_RX];
        status[BIT_TXRDY]  = txrdy;
        status[BIT_UNRE]   = stk_q[STK_UNRE];
        status[BIT_NACK]   = stk_q[STK_NACK];
        dma_tx_req         = txrdy;
    end

    twi_irq_mask #(.DW(DATA_W), .SRC(SRC_BITS)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_wr(wr_ien), .clr_wr(wr_idis),
        .wdata(bus_wdata), .status(status), .mask(mask), .irq(irq)
    );

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFS_STATUS))     bus_rdata <= status;
            else if (bus_addr == ADDR_W'(OFS_IMASK)) bus_rdata <= mask;
            else                                     bus_rdata <= '0;
        end
    end

    a_r5_three_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> (status[BIT_NACK] && status[BIT_TXCOMP] && status[BIT_TXRDY]));
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & mask))));
    a_r11_read_status: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> (bus_rdata == $past(status)));
endmodule

// File: tb/twi_stat_irq_test.sv
module twi_stat_irq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 0, bus_rd = 0;
    logic [7:0] bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic ev_hold_load = 0, ev_hold_to_shift = 0, ev_shift_empty = 0;
    logic ev_stop_sent = 0, ev_nack = 0, ev_rx_ready = 0, ev_underrun = 0;
    logic irq, dma_tx_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    twi_stat_irq uut (.*);

    // Behavioural reference state
    int m_hold, m_shift, m_stop, m_nack, m_unre, m_rx;
    logic [15:0] m_mask, m_rdata;
    bit m_irq, m_rvalid;

    function automatic logic [15:0] m_status();
        logic [15:0] s = 0;
        s[0] = (m_hold == 0 && m_shift == 0 && m_stop == 1);
        s[1] = (m_rx != 0);
        s[2] = (m_hold == 0);
        s[7] = (m_unre != 0);
        s[8] = (m_nack != 0);
        return s;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [15:0] st;
        bit ld, stt;
        if (!rst_n) begin
            m_hold = 0; m_shift = 0; m_stop = 1; m_nack = 0; m_unre = 0; m_rx = 0;
            m_mask = 0; m_irq = 0; m_rdata = 0; m_rvalid = 0;
        end else begin
            st = m_status();
            ld = ev_hold_load || (bus_wr && bus_addr == 8'h34);
            stt = bus_wr && bus_addr == 8'h00 && bus_wdata[0];
            m_rvalid = bus_rd;
            if (bus_rd) m_rdata = (bus_addr == 8'h20) ? st : (bus_addr == 8'h2C) ? m_mask : 16'h0;
            m_irq = |(st & m_mask);
            if (bus_wr && bus_addr == 8'h24) m_mask = m_mask | (bus_wdata & 16'h0187);
            if (bus_wr && bus_addr == 8'h28) m_mask = m_mask & ~bus_wdata;
            if (bus_rd && bus_addr == 8'h20) begin m_nack = 0; m_unre = 0; end
            if (bus_rd && bus_addr == 8'h30) m_rx = 0;
            if (ev_nack) m_nack = 1;
            if (ev_underrun) m_unre = 1;
            if (ev_rx_ready) m_rx = 1;
            if (ev_nack) begin m_hold = 0; m_shift = 0; m_stop = 1; end
            else begin
                if (ld) m_hold = 1; else if (ev_hold_to_shift) m_hold = 0;
                if (ev_hold_to_shift) m_shift = 1; else if (ev_shift_empty) m_shift = 0;
                if (ld || stt) m_stop = 0; else if (ev_stop_sent) m_stop = 1;
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq model", {15'b0, irq}, {15'b0, m_irq});
            chk("R3 dma request model", {15'b0, dma_tx_req}, {15'b0, m_status() >> 2 & 16'h1});
            if (m_rvalid) chk("R11 read data model", bus_rdata, m_rdata);
        end
    end

    task automatic wr(logic [7:0] a, logic [15:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_exp(logic [7:0] a, logic [15:0] exp, string tag);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(ref logic ev);
        ev = 1;
        @(negedge clk);
        ev = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk("R1 irq after reset", {15'b0, irq}, 16'h0);
        chk("R1 dma request after reset", {15'b0, dma_tx_req}, 16'h1);
        rd_exp(8'h20, 16'h0005, "R1 status after reset");
        rd_exp(8'h2C, 16'h0000, "R1 mask after reset");
        rd_exp(8'h20, 16'h0005, "R2 read keeps txcomp");
        // Transmit walk
        wr(8'h34, 16'h00A5);
        chk("R3 dma request drops", {15'b0, dma_tx_req}, 16'h0);
        rd_exp(8'h20, 16'h0000, "R3 load clears txcomp and txrdy");
        pulse(ev_hold_to_shift);
        rd_exp(8'h20, 16'h0004, "R3 txrdy back, R2 shifter busy");
        pulse(ev_shift_empty);
        rd_exp(8'h20, 16'h0004, "R2 no STOP yet");
        pulse(ev_stop_sent);
        rd_exp(8'h20, 16'h0005, "R2 STOP completes");
        // START handling
        wr(8'h00, 16'h0000);
        rd_exp(8'h20, 16'h0005, "R4 control without START");
        wr(8'h00, 16'h0001);
        rd_exp(8'h20, 16'h0004, "R4 START clears txcomp");
        pulse(ev_stop_sent);
        // NACK during a DMA load
        pulse(ev_hold_load);
        rd_exp(8'h20, 16'h0000, "R3 DMA load");
        pulse(ev_nack);
        rd_exp(8'h20, 16'h0105, "R5 NACK sets three flags");
        rd_exp(8'h20, 16'h0005, "R6 read cleared NACK");
        pulse(ev_underrun);
        rd_exp(8'h20, 16'h0085, "R6 underrun sticky");
        rd_exp(8'h20, 16'h0005, "R6 read cleared underrun");
        // Read and underrun in the same cycle
        bus_rd = 1; bus_addr = 8'h20; ev_underrun = 1;
        @(negedge clk);
        bus_rd = 0; ev_underrun = 0;
        chk("R6 read sees old value", bus_rdata, 16'h0005);
        rd_exp(8'h20, 16'h0085, "R6 event beats clear");
        rd_exp(8'h20, 16'h0005, "R6 cleared afterwards");
        // Receive ready
        pulse(ev_rx_ready);
        rd_exp(8'h20, 16'h0007, "R7 rx ready set");
        rd_exp(8'h30, 16'h0000, "R11 rx holding reads zero");
        rd_exp(8'h20, 16'h0005, "R7 rx ready cleared");
        // Mask and interrupt
        wr(8'h24, 16'hFFFF);
        chk("R9 irq one cycle later", {15'b0, irq}, 16'h0);
        @(negedge clk);
        chk("R9 irq rises", {15'b0, irq}, 16'h1);
        rd_exp(8'h2C, 16'h0187, "R8 only source bits set");
        wr(8'h28, 16'h0005);
        chk("R9 irq holds for a cycle", {15'b0, irq}, 16'h1);
        @(negedge clk);
        chk("R9 irq falls", {15'b0, irq}, 16'h0);
        rd_exp(8'h2C, 16'h0182, "R8 disable clears");
        pulse(ev_nack);
        @(negedge clk);
        chk("R9 NACK interrupt", {15'b0, irq}, 16'h1);
        rd_exp(8'h20, 16'h0105, "R5 NACK status");
        @(negedge clk);
        chk("R6 irq drops after clear", {15'b0, irq}, 16'h0);
        // Read-only offsets
        wr(8'h20, 16'hFFFF);
        wr(8'h2C, 16'h0000);
        rd_exp(8'h2C, 16'h0182, "R10 mask unchanged");
        rd_exp(8'h20, 16'h0005, "R10 status unchanged");
        rd_exp(8'h10, 16'h0000, "R11 unmapped offset");
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule